// File: doc/BRIEF.md
# Framed Capture Line Packer

This block turns a ring of fixed-length capture slices into a stream of 16-bit active-video words. A video timing source pulls the words one at a time with a request strobe. When the first word of a line is requested, the block checks the ring.

- If a filled slice is waiting, the block streams that slice and steps its consumer (tail) index.
- If the ring is empty, it streams an idle line of zeros instead.

The block overwrites the last two words of every line:

- **Last word (status):** carries the payload length in its low bits. It also carries one nibble of an 8-byte frame record in its top bits. The record is spread over the first sixteen lines of each frame.
- **Second-to-last word (CRC):** carries a CRC16 that finished a fixed number of lines earlier.

A host that receives the picture can use these fields in three ways. It can tell data lines from filler lines. It can rebuild the frame record. It can check each line's integrity after the fact.

The producer owns the head index and writes the slices. The packer reads slice words through a plain combinational read port. A frame-start pulse marks each new frame. It bumps the frame counter and restarts the line numbering. The pulse is given between lines.

Top module: `line_packer`

## Requirements
- R1: A word requested with `pix_req` (while `frame_start` is low) appears on `pix_data` with `pix_valid` high after the next rising clock edge. `pix_valid` is low after any edge without an accepted request. After reset `pix_valid` and `pix_data` are 0.
- R2: The ring counts as empty when `head_idx` equals (tail + 1) mod SLICES at the first word of a line. In that case the line is idle:
  - its data words are 0;
  - status bits 11:0 are 0;
  - the tail does not move.
  
  Each idle line's status is built only from its own line number, whatever lines came before it.
- R3: The tail resets to SLICES-1. A non-empty line sends words 0..LINE_WORDS-3 of slice `tail`, read at address tail*LINE_WORDS + word. The tail then steps by one, wrapping to 0. Status bits 11:0 equal PAYLOAD_LEN.
- R4: The frame record has eight bytes, numbered k from 0 to 7:

  | k | Contents |
  |---|---|
  | 0 | 0xB1 |
  | 1 | 0xCA |
  | 2 | 0x7A |
  | 3 | 0xDA |
  | 4 | frame counter bits 7:0 |
  | 5 | frame counter bits 15:8 |
  | 6 | PACK_STATE |
  | 7 | CRC_LAG (the CRC mode) |
- R5: On line n of a frame (counted from 0 after `frame_start`), status bits 15:12 depend on n:
  - n < 16 and n odd: bits 7:4 of record byte n/2;
  - n < 16 and n even: bits 3:0 of record byte n/2;
  - n ≥ 16: 0.
- R6: The frame counter resets to 0. It rises by one, mod 2^16, at each `frame_start`, and the new value is used for the frame that follows.
- R7: Every line has its own CRC16, computed as follows:
  - polynomial 0x1021, no reflection;
  - seeded with 0xFFFF at the line's first word;
  - fed each word as sent, MSB first;
  - covers all LINE_WORDS words, including the CRC and status words.
- R8: The CRC word (word LINE_WORDS-2) of a line holds the CRC of the line CRC_LAG lines before it. This holds across frame boundaries. The word is 0 while fewer than CRC_LAG lines have completed since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse between lines marking a new frame |
| head_idx | input | $clog2(SLICES) | Producer head index into the slice ring |
| rd_addr | output | $clog2(SLICES*LINE_WORDS) | Ring word address, combinational |
| rd_data | input | 16 | Ring word at `rd_addr`, same cycle |
| pix_req | input | 1 | Request for the next pixel word |
| pix_data | output | 16 | Registered pixel word |
| pix_valid | output | 1 | `pix_data` carries a newly requested word |

## Verification
The hardest state to reach from the ports is a CRC word that joins lines of different kinds. It must cover data lines mixed with idle lines, a ring wrap, a request gap and a frame boundary, all inside one CRC_LAG window.

The bench keeps its own model of the tail, the line number, the frame counter and the CRC history. Each directed scenario moves `head_idx` so that filled and empty lines alternate in known places. One scenario runs a single frame for more than sixteen lines, so the tail wraps and the nibble field is seen to clear. Each line is checked word by word against the model.

// File: rtl/lp_pkg.sv
package lp_pkg;
   localparam logic [31:0] REC_MAGIC = 32'hDA7A_CAB1;
   localparam logic [15:0] CRC_SEED  = 16'hFFFF;
   localparam logic [15:0] CRC_POLY  = 16'h1021;
   localparam int          REC_LINES = 16;

   // one 16-bit word into the CRC, MSB first
   function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [15:0] w);
      logic [15:0] r;
      r = c;
      for (int i = 15; i >= 0; i--) begin
         if (r[15] ^ w[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
         else              r = {r[14:0], 1'b0};
      end
      return r;
   endfunction

   // byte k of the little-endian frame record
   function automatic logic [7:0] rec_byte(input logic [2:0] k, input logic [15:0] fc,
                                           input logic [7:0] pack, input logic [7:0] mode);
      case (k)
         3'd0:    return REC_MAGIC[7:0];
         3'd1:    return REC_MAGIC[15:8];
         3'd2:    return REC_MAGIC[23:16];
         3'd3:    return REC_MAGIC[31:24];
         3'd4:    return fc[7:0];
         3'd5:    return fc[15:8];
         3'd6:    return pack;
         default: return mode;
      endcase
   endfunction
endpackage

// File: rtl/lp_ring_ctrl.sv
module lp_ring_ctrl #(
   parameter int SLICES = 4,
   localparam int IW = (SLICES > 1) ? $clog2(SLICES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] head,
   input  logic          take,
   output logic [IW-1:0] tail,
   output logic          empty
);
   logic [IW-1:0] nxt;

   assign nxt   = (tail == IW'(SLICES - 1)) ? '0 : tail + IW'(1);
   assign empty = (head == nxt);

   always_ff @(posedge clk) begin
      if (!rst_n)    tail <= IW'(SLICES - 1);
      else if (take) tail <= nxt;
   end
endmodule

// File: rtl/lp_meta.sv
module lp_meta #(
   parameter logic [7:0] PACK_STATE = 8'h00,
   parameter logic [7:0] CRC_MODE   = 8'd2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        frame_start,
   input  logic        line_done,
   output logic [15:0] fcnt,
   output logic [3:0]  nibble
);
   import lp_pkg::*;

   logic [4:0] line_q;   // saturates at REC_LINES
   logic [7:0] sel_byte;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fcnt   <= '0;
         line_q <= '0;
      end else if (frame_start) begin
         fcnt   <= fcnt + 16'd1;
         line_q <= '0;
      end else if (line_done && line_q != 5'(REC_LINES)) begin
         line_q <= line_q + 5'd1;
      end
   end

   assign sel_byte = rec_byte(line_q[3:1], fcnt, PACK_STATE, CRC_MODE);
   assign nibble   = line_q[4] ? 4'h0 : (line_q[0] ? sel_byte[7:4] : sel_byte[3:0]);
endmodule

// File: rtl/lp_crc.sv
module lp_crc #(
   parameter int CRC_LAG = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        step,
   input  logic        first,
   input  logic        last,
   input  logic [15:0] word,
   output logic [15:0] hist
);
   import lp_pkg::*;

   logic [15:0] acc, acc_nxt;

   assign acc_nxt = crc16_step(first ? CRC_SEED : acc, word);

   always_ff @(posedge clk) begin
      if (!rst_n)    acc <= '0;
      else if (step) acc <= acc_nxt;
   end

   generate
      if (CRC_LAG == 1) begin : g_lag1
         logic [15:0] h1;
         always_ff @(posedge clk) begin
            if (!rst_n)            h1 <= '0;
            else if (step && last) h1 <= acc_nxt;
         end
         assign hist = h1;
      end else begin : g_lag2
         logic [15:0] h1, h2;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               h1 <= '0;
               h2 <= '0;
            end else if (step && last) begin
               h1 <= acc_nxt;
               h2 <= h1;
            end
         end
         assign hist = h2;
      end
   endgenerate
endmodule

// File: rtl/line_packer.sv
module line_packer #(
   parameter int         LINE_WORDS  = 16,
   parameter int         SLICES      = 4,
   parameter int         PAYLOAD_LEN = LINE_WORDS - 2,
   parameter logic [7:0] PACK_STATE  = 8'h00,
   parameter int         CRC_LAG     = 2,
   localparam int IW = (SLICES > 1) ? $clog2(SLICES) : 1,
   localparam int AW = $clog2(SLICES * LINE_WORDS),
   localparam int WW = $clog2(LINE_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start,
   input  logic [IW-1:0] head_idx,
   output logic [AW-1:0] rd_addr,
   input  logic [15:0]   rd_data,
   input  logic          pix_req,
   output logic [15:0]   pix_data,
   output logic          pix_valid
);
   generate
      if (LINE_WORDS < 3) begin : g_bad_line
         $error("line_packer: LINE_WORDS must be at least 3");
      end
      if (SLICES < 2) begin : g_bad_ring
         $error("line_packer: SLICES must be at least 2");
      end
      if (PAYLOAD_LEN < 0 || PAYLOAD_LEN > 4095) begin : g_bad_len
         $error("line_packer: PAYLOAD_LEN must fit in 12 bits");
      end
      if (CRC_LAG != 1 && CRC_LAG != 2) begin : g_bad_lag
         $error("line_packer: CRC_LAG must be 1 or 2");
      end
   endgenerate

   logic [WW-1:0] word_cnt;
   logic          idle_q;
   logic [IW-1:0] slice_q;
   logic [IW-1:0] tail_q;
   logic          ring_empty;
   logic [15:0]   frame_cnt;
   logic [3:0]    nib;
   logic [15:0]   crc_hist;
   logic          first_w, last_w, pen_w, accept, cur_idle;
   logic [IW-1:0] cur_slice;
   logic [15:0]   status_w, word_out;

   assign first_w   = (word_cnt == '0);
   assign last_w    = (word_cnt == WW'(LINE_WORDS - 1));
   assign pen_w     = (word_cnt == WW'(LINE_WORDS - 2));
   assign accept    = pix_req && !frame_start;
   assign cur_idle  = first_w ? ring_empty : idle_q;
   assign cur_slice = first_w ? tail_q : slice_q;
   assign rd_addr   = AW'(AW'(cur_slice) * AW'(LINE_WORDS)) + AW'(word_cnt);
   assign status_w  = {nib, cur_idle ? 12'h000 : 12'(PAYLOAD_LEN)};

   always_comb begin
      if (last_w)        word_out = status_w;
      else if (pen_w)    word_out = crc_hist;
      else if (cur_idle) word_out = 16'h0000;
      else               word_out = rd_data;
   end

   lp_ring_ctrl #(.SLICES(SLICES)) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .head  (head_idx),
      .take  (accept && first_w && !ring_empty),
      .tail  (tail_q),
      .empty (ring_empty)
   );

   lp_meta #(.PACK_STATE(PACK_STATE), .CRC_MODE(8'(CRC_LAG))) u_meta (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .line_done   (accept && last_w),
      .fcnt        (frame_cnt),
      .nibble      (nib)
   );

   lp_crc #(.CRC_LAG(CRC_LAG)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (accept),
      .first (first_w),
      .last  (last_w),
      .word  (word_out),
      .hist  (crc_hist)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_cnt  <= '0;
         idle_q    <= 1'b1;
         slice_q   <= '0;
         pix_data  <= '0;
         pix_valid <= 1'b0;
      end else begin
         pix_valid <= accept;
         if (frame_start) begin
            word_cnt <= '0;
         end else if (accept) begin
            pix_data <= word_out;
            word_cnt <= last_w ? '0 : word_cnt + WW'(1);
            if (first_w) begin
               idle_q  <= ring_empty;
               slice_q <= tail_q;
            end
         end
      end
   end
endmodule

// File: rtl/line_packer_chk.sv
module line_packer_chk #(
   parameter int SLICES = 4,
   localparam int IW = (SLICES > 1) ? $clog2(SLICES) : 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          frame_start,
   input logic          pix_req,
   input logic          pix_valid,
   input logic          first,
   input logic          empty,
   input logic [IW-1:0] tail,
   input logic [15:0]   fcnt
);
   // R1
   req_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_req && !frame_start) |=> pix_valid);
   // R1
   no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_req |=> !pix_valid);
   // R2
   empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_req && !frame_start && first && empty) |=> $stable(tail));
   // R3
   tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_req && !frame_start && first && !empty) |=>
         tail == (($past(tail) == IW'(SLICES - 1)) ? '0 : $past(tail) + IW'(1)));
   // R3
   tail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_req |=> $stable(tail));
   // R6
   frame_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> fcnt == $past(fcnt) + 16'd1);
endmodule

bind line_packer line_packer_chk #(.SLICES(SLICES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .pix_req     (pix_req),
   .pix_valid   (pix_valid),
   .first       (first_w),
   .empty       (ring_empty),
   .tail        (tail_q),
   .fcnt        (frame_cnt)
);

// File: tb/tb_line_packer.sv
module tb_line_packer;
   localparam int CLK_PERIOD = 10;
   localparam int LW    = 16;
   localparam int NS    = 4;
   localparam int PLEN  = LW - 2;
   localparam logic [7:0] PACK = 8'h5A;
   localparam int LAG   = 2;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        frame_start = 0;
   logic [1:0]  head_idx = 0;
   logic [5:0]  rd_addr;
   logic [15:0] rd_data;
   logic        pix_req = 0;
   logic [15:0] pix_data;
   logic        pix_valid;

   logic [15:0] mem [NS*LW];
   int total = 0, bad = 0;
   bit done = 0;

   // bench model
   int          m_tail = NS - 1;
   int          m_line = 0;
   logic [15:0] m_fc = 0;
   logic [15:0] m_h1 = 0, m_h2 = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign rd_data = mem[rd_addr];

   line_packer #(.LINE_WORDS(LW), .SLICES(NS), .PAYLOAD_LEN(PLEN),
                 .PACK_STATE(PACK), .CRC_LAG(LAG)) dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .head_idx(head_idx),
      .rd_addr(rd_addr), .rd_data(rd_data), .pix_req(pix_req),
      .pix_data(pix_data), .pix_valid(pix_valid));

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [15:0] w);
      logic [15:0] r = c;
      for (int i = 15; i >= 0; i--)
         r = (r[15] ^ w[i]) ? ({r[14:0],1'b0} ^ 16'h1021) : {r[14:0],1'b0};
      return r;
   endfunction

   function automatic logic [7:0] rec_ref(input int k);
      case (k)
         0: return 8'hB1;  1: return 8'hCA;  2: return 8'h7A;  3: return 8'hDA;
         4: return m_fc[7:0];  5: return m_fc[15:8];
         6: return PACK;   default: return 8'(LAG);
      endcase
   endfunction

   task automatic req_word(output logic [15:0] w);
      @(negedge clk); pix_req = 1;
      @(negedge clk); pix_req = 0;
      check("R1 valid after request", {15'd0, pix_valid}, 16'd1);
      w = pix_data;
   endtask

   task automatic do_line();
      bit idle = (head_idx == 2'((m_tail + 1) % NS));
      logic [15:0] crc = 16'hFFFF;
      logic [15:0] exp, got;
      logic [3:0]  nib;
      for (int w = 0; w < LW; w++) begin
         if (w == LW-1) begin
            nib = 4'h0;
            if (m_line < 16)
               nib = (m_line % 2) ? rec_ref(m_line/2)[7:4] : rec_ref(m_line/2)[3:0];
            exp = {nib, idle ? 12'h000 : 12'(PLEN)};
            req_word(got);
            check(idle ? "R2 R5 idle status" : "R3 R4 R5 data status", got, exp);
         end else if (w == LW-2) begin
            exp = m_h2;
            req_word(got);
            check("R7 R8 crc word", got, exp);
         end else begin
            exp = idle ? 16'h0 : mem[m_tail*LW + w];
            req_word(got);
            check(idle ? "R2 idle data" : "R3 slice data", got, exp);
         end
         crc = crc_ref(crc, exp);
      end
      m_h2 = m_h1; m_h1 = crc;
      if (!idle) m_tail = (m_tail + 1) % NS;
      if (m_line < 100) m_line++;
   endtask

   task automatic new_frame();
      @(negedge clk); frame_start = 1;
      @(negedge clk); frame_start = 0;
      check("R1 no valid on frame pulse", {15'd0, pix_valid}, 16'd0);
      m_fc++; m_line = 0;
   endtask

   task automatic t_reset();
      check("R1 reset valid", {15'd0, pix_valid}, 16'd0);
      check("R1 reset data", pix_data, 16'd0);
   endtask

   task automatic t_idle_run();
      new_frame();
      head_idx = 2'd0;            // tail 3 -> empty
      for (int i = 0; i < 3; i++) do_line();
   endtask

   task automatic t_data_then_idle();
      head_idx = 2'd2;            // slices 3 and 0 ready, then empty
      for (int i = 0; i < 3; i++) do_line();
   endtask

   task automatic t_long_frame();
      new_frame();
      head_idx = 2'd0;            // tail 1: slices 1,2 then empty
      for (int i = 0; i < 6; i++) do_line();
      head_idx = 2'd3;            // tail 3: slices 3,0,1 then empty (wrap)
      for (int i = 0; i < 12; i++) do_line();
   endtask

   task automatic t_gap();
      @(negedge clk); @(negedge clk); @(negedge clk);
      check("R1 no request no valid", {15'd0, pix_valid}, 16'd0);
      do_line();
   endtask

   task automatic t_frames();
      for (int f = 0; f < 2; f++) begin
         new_frame();
         head_idx = 2'((m_tail + 2) % NS);   // one slice ready
         for (int i = 0; i < 12; i++) do_line();
      end
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      if (!done) begin
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NS*LW; i++) mem[i] = 16'((i * 16'h0137) ^ 16'h5A00);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_idle_run();
      t_data_then_idle();
      t_long_frame();
      t_gap();
      t_frames();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule